// File: doc/BRIEF.md
# Filtered Input Capture Channel

This block records the moment an external trigger changes. It follows a single trigger pin, detects the edge polarity chosen by software, and on a qualifying edge copies the current value of a free-running base timer into a capture register. In the same cycle it raises a one-cycle capture strobe. The base timer value, a compare value and the timer's clock enable come from outside the block.

The trigger first passes through a two-stage synchroniser. It can then be cleaned by a noise filter, which accepts a new level only after three consecutive samples agree. The samples are taken either on every system clock or only on cycles where the timer's clock enable is high. A prescaler can thin the captures so that only every (n+1)th qualified edge is recorded. A gate can lock the channel after each capture until software releases it, or until the base timer reaches the compare value.

All settings are loaded together by a single-cycle write strobe. A software gate release is requested by setting the release bit during such a write.

Top module: `fcap_channel`

## Requirements
- R1: Edge field `cfg_edge` selects the trigger: 2'b00 no capture, 2'b01 rising, 2'b10 falling, 2'b11 both edges. All `cfg_*` fields take effect on a cycle where `cfg_we` is 1.
- R2: Without filtering, a trigger change set up before clock edge E1 loads `cap_value` at edge E3 with the `tmr_value` present at E3. `cap_strobe` is high for exactly the cycle following E3.
- R3: Filter field `cfg_filt` is 2'b00 none, 2'b10 sampled on `tmr_tick`, 2'b11 sampled every clock. 2'b01 is treated as none.
- R4: With every-clock filtering, a trigger pulse shorter than three samples produces no capture. A stable change is captured at edge E6 instead of E3.
- R5: With `tmr_tick`-sampled filtering, the filtered level does not move while `tmr_tick` is 0. A held trigger change is captured once `tmr_tick` returns to 1.
- R6: With `cfg_pre_en`=1 and divider n=`cfg_div` (8 bit), captures occur on every (n+1)th qualified edge. The first period after enabling is n edges, and n=0 captures every edge.
- R7: With `cfg_gate_en`=1, the gate closes at each capture. Later edges are then neither captured nor counted by the prescaler until the gate is released.
- R8: A write with `cfg_gate_clr`=1 while the gate is enabled releases the gate.
- R9: With `cfg_match_sel`=1 and the gate enabled, the gate is released on a cycle where `tmr_value` equals `cmp_value`. A capture in that same cycle keeps the gate closed.
- R10: With `cfg_gate_en`=0, the gate never blocks an edge, and the release and match bits have no effect.
- R11: Reset clears all settings (no capture, no filter, no prescaler, no gate), `cap_value` and `cap_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Loads all cfg fields this cycle |
| cfg_edge | input | 2 | Edge select |
| cfg_filt | input | 2 | Filter select |
| cfg_pre_en | input | 1 | Prescaler enable |
| cfg_gate_en | input | 1 | Gate enable |
| cfg_match_sel | input | 1 | Gate release on compare match |
| cfg_gate_clr | input | 1 | Software gate release (with cfg_we) |
| cfg_div | input | 8 | Prescaler setting n |
| tmr_tick | input | 1 | Base timer clock enable |
| tmr_value | input | 16 | Base timer value |
| cmp_value | input | 16 | Compare value for gate release |
| trig_in | input | 1 | Asynchronous trigger pin |
| cap_value | output | 16 | Captured timer value |
| cap_strobe | output | 1 | One-cycle capture event |

## Verification
Two gate functions can fall in the same clock edge: a capture, which closes the gate, and a compare match, which releases it. The bench provokes this by setting `cmp_value` to the timer value that the capture edge is known to sample, three cycles after the trigger rises. It judges the outcome by driving a further trigger edge and confirming that no strobe follows. It then confirms that a software release reopens the channel.

// File: rtl/fcap_pkg.sv
// Shared encodings for the filtered input capture channel.
// Assumes the two-bit field codes listed in the brief.
package fcap_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        FLT_OFF  = 2'b00,
        FLT_RSV  = 2'b01,
        FLT_TICK = 2'b10,
        FLT_CLK  = 2'b11
    } filt_sel_e;
endpackage

// File: rtl/fcap_cond.sv
// Trigger conditioning: synchroniser, optional majority-free agreement
// filter, and edge detection. Assumes SYNC_STAGES >= 2, FILT_DEPTH >= 3.
// Output edge_hit is combinational, valid the cycle after the level moves.
module fcap_cond
    import fcap_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_DEPTH  = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      trig_in,
    input  logic      tmr_tick,
    input  filt_sel_e filt_sel,
    input  edge_sel_e edge_sel,
    output logic      edge_hit
);
    localparam int HW = FILT_DEPTH - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_out;
    logic [HW-1:0]          hist_q;
    logic [HW:0]            window;
    logic                   filt_q;
    logic                   filter_on;
    logic                   sample_en;
    logic                   level;
    logic                   prev_q;
    logic                   rise;
    logic                   fall;

    // Move the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], trig_in};
    end
    assign sync_out = sync_q[SYNC_STAGES-1];

    // Filter mode decode and sample qualifier.
    always_comb begin
        filter_on = (filt_sel == FLT_TICK) || (filt_sel == FLT_CLK);
        sample_en = (filt_sel == FLT_CLK) || ((filt_sel == FLT_TICK) && tmr_tick);
    end

    assign window = {hist_q, sync_out};

    // Keep sample history and accept a level once the window agrees.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            filt_q <= 1'b0;
        end else if (sample_en) begin
            hist_q <= window[HW-1:0];
            if (&window)       filt_q <= 1'b1;
            else if (~|window) filt_q <= 1'b0;
        end
    end

    assign level = filter_on ? filt_q : sync_out;

    // Remember the previous conditioned level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // Select the requested polarity.
    always_comb begin
        rise = level & ~prev_q;
        fall = ~level & prev_q;
        unique case (edge_sel)
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_BOTH: edge_hit = rise | fall;
            default:   edge_hit = 1'b0;
        endcase
    end

    // R5: a tick-sampled filter holds its level while the tick is low
    // R5
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_sel == FLT_TICK && !tmr_tick) |=> $stable(filt_q));
endmodule

// File: rtl/fcap_prescale.sv
// Edge prescaler: passes every (n+1)th qualified edge; while disabled the
// count is parked at 1 so the first period after enabling is n edges.
module fcap_prescale #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] div,
    input  logic          edge_in,
    output logic          fire
);
    logic [PW-1:0] cnt_q;

    // Decide whether this qualified edge produces a capture.
    always_comb begin
        fire = edge_in && (!en || (cnt_q >= div));
    end

    // Count qualified edges, restart after each capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= PW'(1);
        else if (!en)     cnt_q <= PW'(1);
        else if (edge_in) cnt_q <= fire ? '0 : cnt_q + PW'(1);
    end

    // R6: a capture while enabled always restarts the count
    // R6
    pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fire) |=> (cnt_q == '0 || !en));
endmodule

// File: rtl/fcap_gate.sv
// Capture gate: closes on each capture while enabled, reopens on a
// software release or a timer/compare match. A capture wins a tie.
module fcap_gate #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate_en,
    input  logic          match_sel,
    input  logic          sw_clr,
    input  logic [TW-1:0] tmr_value,
    input  logic [TW-1:0] cmp_value,
    input  logic          capture,
    output logic          open
);
    logic closed_q;
    logic release_req;

    // Collect the release sources.
    always_comb begin
        release_req = sw_clr || (match_sel && (tmr_value == cmp_value));
    end

    // Gate state update.
    always_ff @(posedge clk) begin
        if (!rst_n)            closed_q <= 1'b0;
        else if (!gate_en)     closed_q <= 1'b0;
        else if (capture)      closed_q <= 1'b1;
        else if (release_req)  closed_q <= 1'b0;
    end

    assign open = ~closed_q;

    // R7 / R9: a capture with the gate enabled closes it, even on a match
    // R7
    gate_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && capture) |=> !open);

    // R10: a disabled gate is open in the following cycle
    // R10
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> open);
endmodule

// File: rtl/fcap_channel.sv
// Filtered input capture channel top. Holds the settings, joins the
// conditioner, gate and prescaler, and owns the capture register.
// Assumes tmr_value is synchronous to clk.
module fcap_channel
    import fcap_pkg::*;
#(
    parameter int TW          = 16,
    parameter int PW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_DEPTH  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_edge,
    input  logic [1:0]    cfg_filt,
    input  logic          cfg_pre_en,
    input  logic          cfg_gate_en,
    input  logic          cfg_match_sel,
    input  logic          cfg_gate_clr,
    input  logic [PW-1:0] cfg_div,
    input  logic          tmr_tick,
    input  logic [TW-1:0] tmr_value,
    input  logic [TW-1:0] cmp_value,
    input  logic          trig_in,
    output logic [TW-1:0] cap_value,
    output logic          cap_strobe
);
    edge_sel_e     edge_q;
    filt_sel_e     filt_q;
    logic          pre_en_q;
    logic          gate_en_q;
    logic          match_q;
    logic [PW-1:0] div_q;
    logic          edge_hit;
    logic          gate_open;
    logic          qual_edge;
    logic          capture;
    logic          sw_clr;

    // Settings register, loaded as one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q    <= EDGE_NONE;
            filt_q    <= FLT_OFF;
            pre_en_q  <= 1'b0;
            gate_en_q <= 1'b0;
            match_q   <= 1'b0;
            div_q     <= '0;
        end else if (cfg_we) begin
            edge_q    <= edge_sel_e'(cfg_edge);
            filt_q    <= filt_sel_e'(cfg_filt);
            pre_en_q  <= cfg_pre_en;
            gate_en_q <= cfg_gate_en;
            match_q   <= cfg_match_sel;
            div_q     <= cfg_div;
        end
    end

    assign sw_clr = cfg_we && cfg_gate_clr;

    fcap_cond #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_DEPTH  (FILT_DEPTH)
    ) i_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .tmr_tick (tmr_tick),
        .filt_sel (filt_q),
        .edge_sel (edge_q),
        .edge_hit (edge_hit)
    );

    assign qual_edge = edge_hit && gate_open;

    fcap_prescale #(
        .PW (PW)
    ) i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (pre_en_q),
        .div     (div_q),
        .edge_in (qual_edge),
        .fire    (capture)
    );

    fcap_gate #(
        .TW (TW)
    ) i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_en   (gate_en_q),
        .match_sel (match_q),
        .sw_clr    (sw_clr),
        .tmr_value (tmr_value),
        .cmp_value (cmp_value),
        .capture   (capture),
        .open      (gate_open)
    );

    // Capture register and its event strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_value  <= '0;
            cap_strobe <= 1'b0;
        end else begin
            cap_strobe <= capture;
            if (capture) cap_value <= tmr_value;
        end
    end

    // R2: the captured value only moves together with the strobe
    // R2
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_value) |-> cap_strobe);

    // R1: with no capture selected, no strobe follows
    // R1
    no_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_q == EDGE_NONE) |=> !cap_strobe);
endmodule

// File: tb/test_fcap_channel.sv
module test_fcap_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_edge = 2'b00;
    logic [1:0]  cfg_filt = 2'b00;
    logic        cfg_pre_en = 1'b0;
    logic        cfg_gate_en = 1'b0;
    logic        cfg_match_sel = 1'b0;
    logic        cfg_gate_clr = 1'b0;
    logic [7:0]  cfg_div = 8'd0;
    logic        tmr_tick = 1'b1;
    logic [15:0] tcnt = 16'd0;
    logic [15:0] cmp_value = 16'hFFFF;
    logic        trig_in = 1'b0;
    logic [15:0] cap_value;
    logic        cap_strobe;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) tcnt <= tcnt + 16'd1;

    always @(negedge clk) if (rst_n && cap_strobe) strobes++;

    fcap_channel i_fcap_channel (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_edge(cfg_edge),
        .cfg_filt(cfg_filt), .cfg_pre_en(cfg_pre_en), .cfg_gate_en(cfg_gate_en),
        .cfg_match_sel(cfg_match_sel), .cfg_gate_clr(cfg_gate_clr),
        .cfg_div(cfg_div), .tmr_tick(tmr_tick), .tmr_value(tcnt),
        .cmp_value(cmp_value), .trig_in(trig_in), .cap_value(cap_value),
        .cap_strobe(cap_strobe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [1:0] e, input logic [1:0] f, input logic pe,
                             input logic ge, input logic ms, input logic clr,
                             input logic [7:0] d);
        @(negedge clk);
        cfg_edge = e; cfg_filt = f; cfg_pre_en = pe; cfg_gate_en = ge;
        cfg_match_sel = ms; cfg_gate_clr = clr; cfg_div = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; cfg_gate_clr = 1'b0;
    endtask

    // Drive trigger to lvl and check capture exactly at edge lat.
    task automatic exact(input logic lvl, input int lat, input string tag);
        logic [15:0] c;
        @(negedge clk);
        trig_in = lvl;
        c = tcnt;
        repeat (lat - 1) @(negedge clk);
        check(cap_strobe == 1'b0, {tag, " early strobe"}, cap_strobe, 0);
        @(negedge clk);
        check(cap_strobe == 1'b1, {tag, " strobe"}, cap_strobe, 1);
        check(cap_value == c + 16'(lat - 1), {tag, " value"}, cap_value, c + 16'(lat - 1));
        @(negedge clk);
        check(cap_strobe == 1'b0, {tag, " strobe width"}, cap_strobe, 0);
        repeat (8) @(negedge clk);
    endtask

    // High pulse of w cycles, returns strobes seen over the whole pulse.
    task automatic pulse(input int w, output int n);
        int s0;
        @(negedge clk);
        s0 = strobes;
        trig_in = 1'b1;
        repeat (w) @(negedge clk);
        trig_in = 1'b0;
        repeat (12) @(negedge clk);
        n = strobes - s0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(cap_strobe == 1'b0 && cap_value == 16'd0, "R11 reset outputs", cap_value, 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_no_meas;
        int n;
        pulse(4, n);
        check(n == 0, "R11 R1 default no capture", n, 0);
        write_cfg(2'b00, 2'b00, 0, 0, 0, 0, 0);
        pulse(4, n);
        check(n == 0, "R1 edge none", n, 0);
    endtask

    task automatic t_edges;
        write_cfg(2'b01, 2'b00, 0, 0, 0, 0, 0);
        exact(1'b1, 3, "R2 rising");
        begin
            int s0 = strobes;
            @(negedge clk) trig_in = 1'b0;
            repeat (8) @(negedge clk);
            check(strobes == s0, "R1 falling ignored in rise mode", strobes - s0, 0);
        end
        write_cfg(2'b10, 2'b00, 0, 0, 0, 0, 0);
        @(negedge clk) trig_in = 1'b1;
        repeat (8) @(negedge clk);
        exact(1'b0, 3, "R1 falling");
        write_cfg(2'b11, 2'b00, 0, 0, 0, 0, 0);
        begin
            int n;
            pulse(5, n);
            check(n == 2, "R1 both edges", n, 2);
        end
    endtask

    task automatic t_filter;
        int n;
        write_cfg(2'b01, 2'b01, 0, 0, 0, 0, 0);
        pulse(1, n);
        check(n == 1, "R3 reserved code acts as no filter", n, 1);
        write_cfg(2'b01, 2'b11, 0, 0, 0, 0, 0);
        repeat (5) @(negedge clk);
        pulse(1, n);
        check(n == 0, "R4 one-cycle glitch", n, 0);
        pulse(2, n);
        check(n == 0, "R4 two-cycle glitch", n, 0);
        exact(1'b1, 6, "R4 filtered rising");
        @(negedge clk) trig_in = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_tick;
        int s0;
        write_cfg(2'b01, 2'b10, 0, 0, 0, 0, 0);
        @(negedge clk);
        tmr_tick = 1'b0;
        s0 = strobes;
        trig_in = 1'b1;
        repeat (12) @(negedge clk);
        check(strobes == s0, "R5 tick low holds filter", strobes - s0, 0);
        tmr_tick = 1'b1;
        repeat (10) @(negedge clk);
        check(strobes == s0 + 1, "R5 tick resumes capture", strobes - s0, 1);
        trig_in = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_prescale;
        int n;
        int got[6];
        write_cfg(2'b01, 2'b00, 1, 0, 0, 0, 8'd2);
        for (int i = 0; i < 6; i++) begin
            pulse(3, n);
            got[i] = n;
        end
        check(got[0] == 0 && got[1] == 1, "R6 first period n edges", got[0] * 10 + got[1], 1);
        check(got[2] == 0 && got[3] == 0 && got[4] == 1, "R6 later period n+1 edges",
              got[2] * 100 + got[3] * 10 + got[4], 1);
        write_cfg(2'b01, 2'b00, 1, 0, 0, 0, 8'd0);
        pulse(3, n);
        check(n == 1, "R6 n=0 every edge", n, 1);
        write_cfg(2'b01, 2'b00, 0, 0, 0, 0, 0);
    endtask

    task automatic t_gate;
        int n;
        write_cfg(2'b01, 2'b00, 0, 1, 0, 0, 0);
        pulse(3, n);
        check(n == 1, "R7 first capture with gate", n, 1);
        pulse(3, n);
        check(n == 0, "R7 gate blocks next edge", n, 0);
        write_cfg(2'b01, 2'b00, 0, 1, 0, 1, 0);
        pulse(3, n);
        check(n == 1, "R8 software release", n, 1);
        // match release
        @(negedge clk) cmp_value = tcnt + 16'd6;
        write_cfg(2'b01, 2'b00, 0, 1, 1, 0, 0);
        repeat (10) @(negedge clk);
        pulse(3, n);
        check(n == 1, "R9 match release", n, 1);
    endtask

    task automatic t_conflict;
        int n;
        logic [15:0] c;
        write_cfg(2'b01, 2'b00, 0, 1, 1, 1, 0);
        @(negedge clk);
        trig_in = 1'b1;
        c = tcnt;
        cmp_value = c + 16'd2;
        repeat (3) @(negedge clk);
        check(cap_strobe && cap_value == c + 16'd2, "R9 capture on match cycle", cap_value, c + 16'd2);
        repeat (3) @(negedge clk);
        trig_in = 1'b0;
        repeat (6) @(negedge clk);
        pulse(3, n);
        check(n == 0, "R9 capture beats match release", n, 0);
        write_cfg(2'b01, 2'b00, 0, 1, 0, 1, 0);
        pulse(3, n);
        check(n == 1, "R8 release after tie", n, 1);
    endtask

    task automatic t_gate_off;
        int n;
        int tot;
        tot = 0;
        @(negedge clk) cmp_value = tcnt + 16'd5;
        write_cfg(2'b01, 2'b00, 0, 0, 1, 1, 0);
        for (int i = 0; i < 3; i++) begin
            pulse(3, n);
            tot += n;
        end
        check(tot == 3, "R10 gate disabled never blocks", tot, 3);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        t_reset();
        t_no_meas();
        t_edges();
        t_filter();
        t_tick();
        t_prescale();
        t_gate();
        t_conflict();
        t_gate_off();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end
endmodule